// File: doc/BRIEF.md
# Interlocked Single-Word Handshake Buffer

This block moves data words from a producing neighbour to a consuming neighbour through one holding register. Each side talks to the block with a fully interlocked four-phase request/grant exchange, so neither side can race ahead of the other. On the producer side, the producer presents a word and raises its request. The block answers with a grant, capturing the word on that same clock edge. The producer then lowers its request, and the block lowers its grant to confirm that the word is held. On the consumer side, the block raises its own request while it holds a word. The consumer raises a grant, the block lowers its request, and the consumer lowers its grant to confirm the read.

All three parties share one clock. The block updates on rising edges. Both neighbours are expected to change their signals on falling edges, so each side sees the other's change at the next rising edge. A new producer grant is never issued while a word is still waiting to be read. A producer that asks while the register is occupied just keeps its request high until the register frees up.

Top module: `handshake_buffer`

## Requirements
- R1: While reset is low, and on the first falling edge after it rises, `prod_gnt` and `cons_req` are 0. The register starts empty, so a request made straight after reset is granted at once.
- R2: When `prod_gnt` is low and the buffer is free, `prod_gnt` rises on the first rising edge that samples `prod_req` high. `prod_gnt` never rises on an edge that samples `prod_req` low.
- R3: On the first rising edge that samples `prod_req` low while `prod_gnt` is high, `prod_gnt` falls and `cons_req` rises together. `cons_req` rises on no other edge.
- R4: `cons_req` falls on the first rising edge that samples `cons_gnt` high while `cons_req` is high.
- R5: From the edge that raises `prod_gnt` until a rising edge samples `cons_gnt` low after `cons_req` has fallen, the buffer is occupied, and `prod_gnt` does not rise during that time.
- R6: When `cons_req` rises, `cons_data` equals the `prod_data` value sampled on the edge where `prod_gnt` rose.
- R7: `cons_data` does not change while a word is held and either `cons_req` or `cons_gnt` is high.
- R8: A producer request made while the buffer is occupied stays pending. It is granted on the same edge that first samples `cons_gnt` low after `cons_req` has fallen, without the producer re-requesting.
- R9: With a producer that re-requests on the falling edge after `prod_gnt` falls, and a consumer that answers each change on the next falling edge, `prod_gnt` rises exactly every 3 clock cycles.
- R10: `prod_gnt` stays high while `prod_req` is sampled high. `cons_req` stays high while `cons_gnt` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; the block acts on rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_data | input | DATA_W | Word offered by the producer |
| prod_req | input | 1 | Producer request, held high while `prod_data` is valid |
| prod_gnt | output | 1 | Grant to the producer; rises on capture, falls once the word is held |
| cons_data | output | DATA_W | Held word presented to the consumer |
| cons_req | output | 1 | Request to the consumer while an unread word is offered |
| cons_gnt | input | 1 | Consumer grant; its fall marks the word as read |

## Verification
An output-side state stuck in the offering phase would show up on the port as `cons_req` staying high one edge after a sampled consumer grant. An occupancy state that frees up too early would show up as a producer grant rising while the previous word is still unread. Both faults are visible on the first falling edge after the rising edge where they occur. A capture enable firing at the wrong time would change `cons_data` during the consumer exchange, or would make the offered word differ from the one the producer presented. Either error appears on the sample right after the faulty edge. A release of the grant that is one cycle slow, or that overlaps another step, stretches the back-to-back spacing away from three cycles, and this shows up by the second transfer of the eager phase.

// File: rtl/hsbuf_pkg.sv
// Shared types for the single-word handshake buffer.
// Assumes: nothing beyond a synthesizable two-bit encoding.
package hsbuf_pkg;

    // Occupancy and offer phase of the holding register, seen from the consumer side.
    typedef enum logic [1:0] {
        OS_EMPTY = 2'd0,  // no unread word held
        OS_OFFER = 2'd1,  // word held, request to consumer raised
        OS_DRAIN = 2'd2   // request dropped, waiting for consumer grant to fall
    } out_state_t;

endpackage

// File: rtl/hsbuf_in_ctl.sv
// Producer-side controller: issues the grant and the capture strobe.
// Assumes: prod_req changes only on falling edges; slot_free comes from the
// consumer-side controller and is valid before each rising edge.
module hsbuf_in_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic prod_req,
    input  logic slot_free,
    output logic prod_gnt,
    output logic load,
    output logic store
);

    logic gnt_q;

    // Capture happens on the edge that raises the grant.
    assign load     = prod_req & ~gnt_q & slot_free;
    // Request withdrawn while granted: the word is now committed.
    assign store    = gnt_q & ~prod_req;
    assign prod_gnt = gnt_q;

    // Grant flop: set on capture, cleared once the producer lets go.
    always_ff @(posedge clk) begin
        if (!rst_n)     gnt_q <= 1'b0;
        else if (load)  gnt_q <= 1'b1;
        else if (store) gnt_q <= 1'b0;
    end

endmodule

// File: rtl/hsbuf_out_ctl.sv
// Consumer-side controller: tracks occupancy and drives the consumer request.
// Assumes: cons_gnt changes only on falling edges, and the consumer follows the
// four-phase order (grant up after request, grant down after request drops).
module hsbuf_out_ctl
    import hsbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic store,
    input  logic cons_gnt,
    output logic cons_req,
    output logic slot_free
);

    out_state_t st_q, st_d;

    // Free when empty, or when the read completes on this very edge.
    assign slot_free = (st_q == OS_EMPTY) || ((st_q == OS_DRAIN) && !cons_gnt);
    assign cons_req  = (st_q == OS_OFFER);

    // Next-phase selection for the consumer exchange.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OS_EMPTY: if (store)     st_d = OS_OFFER;
            OS_OFFER: if (cons_gnt)  st_d = OS_DRAIN;
            OS_DRAIN: if (!cons_gnt) st_d = OS_EMPTY;
            default:                 st_d = OS_EMPTY;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OS_EMPTY;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/hsbuf_word_reg.sv
// Holding register for one data word.
// Assumes: load is asserted only when the register holds no unread word.
module hsbuf_word_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Capture the producer word when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/handshake_buffer.sv
// Top level: one-word buffer between two interlocked four-phase handshakes.
// Assumes: both neighbours share clk and change their outputs on falling edges.
module handshake_buffer #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              prod_req,
    output logic              prod_gnt,
    output logic [DATA_W-1:0] cons_data,
    output logic              cons_req,
    input  logic              cons_gnt
);

    logic load, store, slot_free;

    hsbuf_in_ctl u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_req  (prod_req),
        .slot_free (slot_free),
        .prod_gnt  (prod_gnt),
        .load      (load),
        .store     (store)
    );

    hsbuf_out_ctl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (store),
        .cons_gnt  (cons_gnt),
        .cons_req  (cons_req),
        .slot_free (slot_free)
    );

    hsbuf_word_reg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (prod_data),
        .q     (cons_data)
    );

endmodule

// File: rtl/hsbuf_checker.sv
// Protocol checker bound to handshake_buffer; observes ports only.
module hsbuf_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] prod_data,
    input logic              prod_req,
    input logic              prod_gnt,
    input logic [DATA_W-1:0] cons_data,
    input logic              cons_req,
    input logic              cons_gnt
);

    // R2: a grant only answers a sampled request.
    a_r2_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prod_gnt) |-> $past(prod_req));

    // R2/R6: the captured word is the one presented at the grant edge.
    a_r6_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prod_gnt) |-> (cons_data == $past(prod_data)));

    // R3: grant release and consumer request happen together.
    a_r3_store_offer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prod_gnt) |-> $rose(cons_req));

    // R4: consumer grant withdraws the request on the next edge.
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_req && cons_gnt) |=> !cons_req);

    // R5: no new grant while the consumer exchange is in progress.
    a_r5_no_grant_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prod_gnt) |-> (!$past(cons_req) && !$past(cons_gnt)));

    // R7: offered word holds still during the consumer exchange.
    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cons_req || cons_gnt) |-> $stable(cons_data));

    // R10: interlock on both sides.
    a_r10_gnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_gnt && prod_req) |=> prod_gnt);
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_req && !cons_gnt) |=> cons_req);

endmodule

bind handshake_buffer hsbuf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_data (prod_data),
    .prod_req  (prod_req),
    .prod_gnt  (prod_gnt),
    .cons_data (cons_data),
    .cons_req  (cons_req),
    .cons_gnt  (cons_gnt)
);

// File: tb/handshake_buffer_bench.sv
module handshake_buffer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] prod_data = '0;
    logic         prod_req = 1'b0;
    logic         cons_gnt = 1'b0;
    logic         prod_gnt, cons_req;
    logic [W-1:0] cons_data;

    handshake_buffer #(.DATA_W(W)) u_handshake_buffer (
        .clk(clk), .rst_n(rst_n), .prod_data(prod_data), .prod_req(prod_req),
        .prod_gnt(prod_gnt), .cons_data(cons_data), .cons_req(cons_req), .cons_gnt(cons_gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_grant = 0, grants_in_phase = 0, n_words = 0;
    int p_prob = 50, c_prob = 50;
    bit eager = 1'b0;
    bit held = 1'b0, drained = 1'b0;
    logic [W-1:0] exp_word = '0, p_data = '0;
    logic p_req = 0, p_gnt = 0, p_creq = 0, p_cgnt = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Occupancy as the requirements define it (R5, R8).
    function automatic bit exp_free(input bit h, input bit d, input logic pg);
        return !h || (d && !pg);
    endfunction

    function automatic bit chance(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic step();
        bit fr, rose;
        @(negedge clk);
        cyc++;
        fr   = exp_free(held, drained, p_cgnt);
        rose = !p_gnt && prod_gnt;
        if (!p_gnt) begin
            if (p_req && fr)  check(prod_gnt == 1'b1, held ? "R8 pending grant" : "R2 grant", prod_gnt, 1);
            else if (!p_req)  check(prod_gnt == 1'b0, "R2 no grant without request", prod_gnt, 0);
            else              check(prod_gnt == 1'b0, "R5 grant while occupied", prod_gnt, 0);
        end else if (p_req) begin
            check(prod_gnt == 1'b1, "R10 grant hold", prod_gnt, 1);
        end else begin
            check(prod_gnt == 1'b0, "R3 grant release", prod_gnt, 0);
            check(cons_req == 1'b1, "R3 consumer request", cons_req, 1);
        end
        if (p_creq) begin
            if (p_cgnt) check(cons_req == 1'b0, "R4 request drop", cons_req, 0);
            else        check(cons_req == 1'b1, "R10 request hold", cons_req, 1);
        end else if (!(p_gnt && !p_req)) begin
            check(cons_req == 1'b0, "R3 stray consumer request", cons_req, 0);
        end
        if (rose) begin
            if (eager && grants_in_phase >= 2)
                check(cyc - last_grant == 3, "R9 spacing", cyc - last_grant, 3);
            grants_in_phase++;
            last_grant = cyc;
            exp_word   = p_data;
            held       = 1'b1;
            drained    = 1'b0;
        end else if (held && drained && !p_cgnt) begin
            held    = 1'b0;
            drained = 1'b0;
        end
        if (!p_creq && cons_req)
            check(cons_data == exp_word, "R6 offered word", cons_data, exp_word);
        if (held && (cons_req || cons_gnt))
            check(cons_data == exp_word, "R7 stable word", cons_data, exp_word);
        if (p_creq && !cons_req) drained = 1'b1;

        // Neighbours act on the falling edge.
        if (prod_req && prod_gnt) begin
            if (eager || chance(p_prob)) prod_req = 1'b0;
        end else if (!prod_req && !prod_gnt && (eager || chance(p_prob))) begin
            prod_data = W'($urandom);
            prod_req  = 1'b1;
        end
        if (cons_req && !cons_gnt) begin
            if (eager || chance(c_prob)) cons_gnt = 1'b1;
        end else if (!cons_req && cons_gnt) begin
            if (eager || chance(c_prob)) begin cons_gnt = 1'b0; n_words++; end
        end
        p_req = prod_req; p_gnt = prod_gnt; p_creq = cons_req; p_cgnt = cons_gnt; p_data = prod_data;
    endtask

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        check(prod_gnt == 1'b0, "R1 reset grant", prod_gnt, 0);
        check(cons_req == 1'b0, "R1 reset request", cons_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(prod_gnt == 1'b0 && cons_req == 1'b0, "R1 after reset", {prod_gnt, cons_req}, 0);
        // Directed: request right after reset is granted on the next edge (R1, R2).
        prod_data = 16'hA5C3; prod_req = 1'b1;
        p_req = 1'b1; p_data = prod_data;
        step();
        check(prod_gnt == 1'b1, "R1 empty after reset", prod_gnt, 1);
        // Random traffic.
        repeat (1500) step();
        // Slow consumer, eager producer: pending requests (R8).
        p_prob = 100; c_prob = 10;
        repeat (800) step();
        // Drain, then back-to-back traffic (R9).
        p_prob = 0; c_prob = 100;
        repeat (40) step();
        eager = 1'b1; grants_in_phase = 0;
        repeat (60) step();
        check(grants_in_phase >= 18, "R9 grant count", grants_in_phase, 18);
        check(n_words > 0, "R9 words transferred", n_words, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule